// File: doc/BRIEF.md
# Auto-Incrementing Lookup-Table Access Window

This block gives a host on a narrow byte-wide register bus access to a set of large on-chip tables through four registers: a table selector, the upper and lower parts of a table pointer, and a data window. Each data-window access reads or writes the byte at the pointer. The pointer then advances by itself, so a whole table can be streamed by repeated accesses to one register. There are three colour-correction tables with one byte per entry, and one coefficient store whose entries are 16 bits wide and move as two bytes.

The table side is a generic memory port with a request, a write enable, a table select, an entry address, two byte-lane enables and a 16-bit read path that returns data in the same cycle. In read direction the block keeps the entry at the pointer already fetched in a holding register. A run of reads can therefore issue one per clock, even straight after the pointer is loaded. Accesses outside the legal range of the chosen table are dropped, and they leave a sticky error bit that the host can see.

Top module: `lut_window_port`

## Requirements
- R1: After reset the selector, pointer-high and pointer-low registers all read back 0x00. The direction is write, the error bit is clear and the byte phase is the first byte.
- R2: Selector register: bit 0 = table kind (0 colour table, 1 coefficient store), bits 2:1 = colour (00 red, 01 green, 10 blue, 11 unused), bit 3 = coefficient range (0 short, 1 long), bit 7 = sticky error (read only). The memory select is the colour code for colour tables and 3 for the coefficient store.
- R3: Pointer-high register: bits 4:0 = pointer bits 12:8, bit 5 = direction (1 read, 0 write). Pointer-low register holds pointer bits 7:0. Both read back what was written. Register offsets are 0 selector, 1 pointer high, 2 pointer low, 3 data window.
- R4: A data-window write to a colour table in write direction stores the byte on lane 0 (byte enables 01) at the pointer, then advances the pointer by one.
- R5: A data-window read of a colour table in read direction returns the entry at the pointer and advances it by one. Reads on consecutive cycles, including one in the cycle right after a pointer write, return consecutive entries.
- R6: In the coefficient store a data write holds the first byte as the low half and issues no memory write. The second byte commits {second, first} with byte enables 11 and advances the pointer by one.
- R7: A coefficient read returns the low byte of the entry, then the high byte, and advances the pointer after the second byte.
- R8: Legal pointers are 0..1023 for colours 00-10, none for colour 11, 0..2729 for the short coefficient range and 0..5459 for the long one.
- R9: A data access in the active direction at an illegal pointer is dropped: no memory write, pointer unchanged, a read returns 0x00. It sets the error bit, which stays set until the next selector write clears it.
- R10: Writing the selector, pointer-high or pointer-low register returns the byte phase to the first byte.
- R11: A data access against the current direction (a write while reading, a read while writing) has no effect: no memory write, pointer and phase unchanged, error unchanged, and a read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one access per cycle |
| host_re | input | 1 | Host read strobe, one access per cycle |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle of host_re |
| mem_req | output | 1 | Table access request |
| mem_we | output | 1 | Table write when set, fetch when clear |
| mem_sel | output | 2 | Table select: colour code or 3 for coefficients |
| mem_addr | output | 13 | Entry address |
| mem_be | output | 2 | Byte-lane enables for writes |
| mem_wdata | output | 16 | Write data, lane 0 in bits 7:0 |
| mem_rdata | input | 16 | Read data returned in the request cycle |

## Verification
The bench builds the block with its default parameters: a 13-bit pointer, 1024-entry colour tables and coefficient limits of 2730 and 5460 entries. With these, every legal entry of every table can be streamed and checked against an arithmetic table model. Each exact last-legal and first-illegal pointer is reached by the sweeps themselves rather than by a scaled-down copy. The bench also checks mid-entry phase resets, direction mismatches and the clearing of the sticky error at these real boundaries.

// File: rtl/lutwin_pkg.sv
package lutwin_pkg;
   typedef enum logic [1:0] {
      REG_TGT = 2'd0,
      REG_PHI = 2'd1,
      REG_PLO = 2'd2,
      REG_DAT = 2'd3
   } lutwin_reg_e;

   localparam int          LW_DIR_BIT  = 5;
   localparam int          LW_LANES    = 2;
   localparam int          LW_MW       = 8 * LW_LANES;
   localparam logic [1:0]  LW_SEL_COEF = 2'd3;
endpackage

// File: rtl/lutwin_bound.sv
module lutwin_bound #(
   parameter int AW          = 13,
   parameter int GAMMA_DEPTH = 1024,
   parameter int COEF_LO     = 2730,
   parameter int COEF_HI     = 5460
) (
   input  logic          kind,
   input  logic [1:0]    col,
   input  logic          hires,
   input  logic [AW-1:0] ptr,
   output logic          legal
);
   localparam logic [AW:0] LIM_G  = GAMMA_DEPTH[AW:0];
   localparam logic [AW:0] LIM_CL = COEF_LO[AW:0];
   localparam logic [AW:0] LIM_CH = COEF_HI[AW:0];

   if (GAMMA_DEPTH > (1 << AW) || COEF_HI > (1 << AW) || COEF_LO > COEF_HI) begin : g_bad_limits
      $error("lutwin_bound: table limits do not fit the pointer width");
   end

   logic [AW:0] ptr_x;
   assign ptr_x = {1'b0, ptr};

   always_comb begin
      if (kind) legal = hires ? (ptr_x < LIM_CH) : (ptr_x < LIM_CL);
      else      legal = (col != 2'b11) && (ptr_x < LIM_G);
   end
endmodule

// File: rtl/lutwin_rdbuf.sv
module lutwin_rdbuf #(
   parameter int LANES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [8*LANES-1:0]       din,
   input  logic [$clog2(LANES)-1:0] lane_sel,
   output logic [7:0]               dout
);
   if (LANES < 2) begin : g_bad_lanes
      $error("lutwin_rdbuf: at least two lanes are needed");
   end

   logic [8*LANES-1:0] buf_q;
   logic [7:0]         lane_v [LANES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    buf_q <= '0;
      else if (load) buf_q <= din;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_v[g] = buf_q[8*g +: 8];
   end

   assign dout = lane_v[lane_sel];
endmodule

// File: rtl/lut_window_port.sv
module lut_window_port
   import lutwin_pkg::*;
#(
   parameter int AW          = 13,
   parameter int GAMMA_DEPTH = 1024,
   parameter int COEF_LO     = 2730,
   parameter int COEF_HI     = 5460
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic             host_re,
   input  logic [1:0]       host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   output logic             mem_req,
   output logic             mem_we,
   output logic [1:0]       mem_sel,
   output logic [AW-1:0]    mem_addr,
   output logic [1:0]       mem_be,
   output logic [LW_MW-1:0] mem_wdata,
   input  logic [LW_MW-1:0] mem_rdata
);
   localparam int HW = AW - 8;

   if (AW < 9 || AW > 13) begin : g_bad_aw
      $error("lut_window_port: AW must lie in 9..13");
   end

   // ---------------- state ----------------
   logic          kind_q, hires_q, dir_q, phase_q, err_q;
   logic [1:0]    col_q;
   logic [AW-1:0] ptr_q;
   logic [7:0]    hold_q;

   logic          kind_d, hires_d, dir_d, phase_d, err_d;
   logic [1:0]    col_d;
   logic [AW-1:0] ptr_d;
   logic [7:0]    hold_d;

   // ---------------- decode ----------------
   lutwin_reg_e ra;
   assign ra = lutwin_reg_e'(host_addr);

   logic wr_tgt, wr_phi, wr_plo, wr_dat, rd_dat;
   assign wr_tgt = host_we && (ra == REG_TGT);
   assign wr_phi = host_we && (ra == REG_PHI);
   assign wr_plo = host_we && (ra == REG_PLO);
   assign wr_dat = host_we && (ra == REG_DAT);
   assign rd_dat = host_re && !host_we && (ra == REG_DAT);

   logic legal_q, legal_d;

   lutwin_bound #(.AW(AW), .GAMMA_DEPTH(GAMMA_DEPTH), .COEF_LO(COEF_LO), .COEF_HI(COEF_HI)) u_bound_cur (
      .kind(kind_q), .col(col_q), .hires(hires_q), .ptr(ptr_q), .legal(legal_q)
   );

   logic acc_rd, acc_wr, acc_bad, rd_go, wr_go, step, commit, fetch;
   assign acc_rd  = rd_dat && dir_q;
   assign acc_wr  = wr_dat && !dir_q;
   assign acc_bad = (acc_rd || acc_wr) && !legal_q;
   assign rd_go   = acc_rd && legal_q;
   assign wr_go   = acc_wr && legal_q;
   assign step    = (rd_go || wr_go) && (!kind_q || phase_q);
   assign commit  = wr_go && (!kind_q || phase_q);

   // ---------------- next state ----------------
   always_comb begin
      kind_d  = kind_q;
      col_d   = col_q;
      hires_d = hires_q;
      dir_d   = dir_q;
      phase_d = phase_q;
      ptr_d   = ptr_q;
      hold_d  = hold_q;
      if (wr_tgt) begin
         kind_d  = host_wdata[0];
         col_d   = host_wdata[2:1];
         hires_d = host_wdata[3];
         phase_d = 1'b0;
      end
      if (wr_phi) begin
         ptr_d[AW-1:8] = host_wdata[HW-1:0];
         dir_d         = host_wdata[LW_DIR_BIT];
         phase_d       = 1'b0;
      end
      if (wr_plo) begin
         ptr_d[7:0] = host_wdata;
         phase_d    = 1'b0;
      end
      if (rd_go || wr_go) begin
         if (kind_q) phase_d = !phase_q;
         if (step)   ptr_d   = ptr_q + 1'b1;
      end
      if (wr_go && kind_q && !phase_q) hold_d = host_wdata;
      err_d = wr_tgt ? 1'b0 : (err_q | acc_bad);
   end

   lutwin_bound #(.AW(AW), .GAMMA_DEPTH(GAMMA_DEPTH), .COEF_LO(COEF_LO), .COEF_HI(COEF_HI)) u_bound_nxt (
      .kind(kind_d), .col(col_d), .hires(hires_d), .ptr(ptr_d), .legal(legal_d)
   );

   // Fetch the entry the pointer will point at, in the same cycle it is set up.
   assign fetch = dir_d && legal_d && (wr_tgt || wr_phi || wr_plo || (rd_go && step));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= 1'b0;
         col_q   <= 2'b00;
         hires_q <= 1'b0;
         dir_q   <= 1'b0;
         phase_q <= 1'b0;
         err_q   <= 1'b0;
         ptr_q   <= '0;
         hold_q  <= '0;
      end else begin
         kind_q  <= kind_d;
         col_q   <= col_d;
         hires_q <= hires_d;
         dir_q   <= dir_d;
         phase_q <= phase_d;
         err_q   <= err_d;
         ptr_q   <= ptr_d;
         hold_q  <= hold_d;
      end
   end

   // ---------------- prefetch buffer ----------------
   logic [7:0] buf_byte;

   lutwin_rdbuf #(.LANES(LW_LANES)) u_rdbuf (
      .clk(clk), .rst_n(rst_n), .load(fetch), .din(mem_rdata),
      .lane_sel(kind_q & phase_q), .dout(buf_byte)
   );

   // ---------------- memory port ----------------
   assign mem_req   = fetch || commit;
   assign mem_we    = commit;
   assign mem_addr  = commit ? ptr_q : ptr_d;
   assign mem_sel   = kind_d ? LW_SEL_COEF : col_d;
   assign mem_be    = (commit && !kind_q) ? 2'b01 : 2'b11;
   assign mem_wdata = kind_q ? {host_wdata, hold_q} : {8'h00, host_wdata};

   // ---------------- host read mux ----------------
   logic [4:0] hi5;
   always_comb begin
      hi5         = '0;
      hi5[HW-1:0] = ptr_q[AW-1:8];
   end

   always_comb begin
      host_rdata = 8'h00;
      if (host_re) begin
         unique case (ra)
            REG_TGT: host_rdata = {err_q, 3'b000, hires_q, col_q, kind_q};
            REG_PHI: host_rdata = {2'b00, dir_q, hi5};
            REG_PLO: host_rdata = ptr_q[7:0];
            REG_DAT: host_rdata = rd_go ? buf_byte : 8'h00;
         endcase
      end
   end

   // ---------------- assertions ----------------
   assert_commit_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (legal_q && !dir_q))
      else $error("memory write at illegal pointer or in read direction");

   assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == 2'd3 && !dir_q && !legal_q) |=> err_q)
      else $error("illegal write did not raise the error bit");

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(host_we && host_addr == 2'd0)) |=> err_q)
      else $error("error bit dropped without a selector write");

   assert_phase_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr != 2'd3) |=> !phase_q)
      else $error("byte phase not reset by a register write");

   assert_gamma_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !kind_q) |-> (mem_be == 2'b01 && mem_sel != LW_SEL_COEF))
      else $error("colour-table write with wrong lanes or select");

   assert_coef_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && kind_q) |-> (phase_q && mem_be == 2'b11))
      else $error("coefficient commit before the second byte");

   assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_re && !host_we && host_addr == 2'd3 && dir_q && legal_q && !kind_q)
      |=> (ptr_q == AW'($past(ptr_q) + 1'b1)))
      else $error("colour-table read did not advance the pointer");

   assert_wrongdir_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == 2'd3 && dir_q) |-> !mem_req)
      else $error("data write in read direction reached the memory");
endmodule

// File: tb/lut_window_port_tb.sv
module lut_window_port_tb;
   localparam int AW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0, host_re = 1'b0;
   logic [1:0]    host_addr = 2'd0;
   logic [7:0]    host_wdata = 8'h00;
   logic [7:0]    host_rdata;
   logic          mem_req, mem_we;
   logic [1:0]    mem_sel, mem_be;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_wdata, mem_rdata;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lut_window_port u_dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] gpat(int s, int a);
      return 8'(a * 3 + s * 85 + (a >> 8) * 17);
   endfunction

   function automatic logic [15:0] cpat(int a);
      return 16'(a * 37 + 16'h1234);
   endfunction

   assign mem_rdata = (mem_req && !mem_we) ?
                      ((mem_sel == 2'd3) ? cpat(int'(mem_addr)) : {8'hEE, gpat(int'(mem_sel), int'(mem_addr))}) :
                      16'hDEAD;

   // write monitor
   int          wcnt = 0;
   logic [1:0]  lw_sel, lw_be;
   logic [AW-1:0] lw_addr;
   logic [15:0] lw_data;
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_we) begin
         wcnt    <= wcnt + 1;
         lw_sel  <= mem_sel;
         lw_be   <= mem_be;
         lw_addr <= mem_addr;
         lw_data <= mem_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic op_wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      host_we = 1'b1; host_re = 1'b0; host_addr = a; host_wdata = d;
   endtask

   task automatic op_rd(input logic [1:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      host_we = 1'b0; host_re = 1'b1; host_addr = a;
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic op_idle();
      @(posedge clk); #1;
      host_we = 1'b0; host_re = 1'b0;
   endtask

   task automatic chk_ptr(input string req, input int exp_ptr, input bit exp_dir);
      logic [7:0] h, l;
      op_rd(2'd1, h);
      op_rd(2'd2, l);
      op_idle();
      chk(h == 8'({exp_dir, 5'(exp_ptr >> 8)}), req, h, {exp_dir, 5'(exp_ptr >> 8)});
      chk(l == 8'(exp_ptr), req, l, 8'(exp_ptr));
   endtask

   task automatic set_ptr(input int p, input bit rd);
      op_wr(2'd1, {2'b00, rd, 5'(p >> 8)});
      op_wr(2'd2, 8'(p));
   endtask

   initial begin
      logic [7:0] d, t;
      int w0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset values
      op_rd(2'd0, t); op_idle();
      chk(t == 8'h00, "R1 selector", t, 0);
      chk_ptr("R1 pointer", 0, 1'b0);
      op_rd(2'd3, d); op_idle();
      chk(d == 8'h00, "R1 data in write dir", d, 0);

      // R2/R3: readback of register fields
      op_wr(2'd0, 8'h0D); op_rd(2'd0, t); op_idle();
      chk(t == 8'h0D, "R2 selector readback", t, 8'h0D);
      op_wr(2'd1, 8'h3F); op_wr(2'd2, 8'hA7);
      chk_ptr("R3 pointer readback", 13'h1FA7, 1'b1);

      // R5/R8/R9: full colour-table read sweeps, back-to-back after pointer load
      for (int s = 0; s < 3; s++) begin
         op_wr(2'd0, 8'(s << 1));
         set_ptr(0, 1'b1);
         for (int i = 0; i < 1024; i++) begin
            op_rd(2'd3, d);
            chk(d == gpat(s, i), "R5 colour read", d, gpat(s, i));
         end
         op_rd(2'd3, d);
         chk(d == 8'h00, "R8 read past 1023", d, 0);
         op_rd(2'd0, t); op_idle();
         chk(t[7] == 1'b1, "R9 error after illegal read", t, 8'h80 | (s << 1));
         chk_ptr("R9 pointer held at 1024", 1024, 1'b1);
      end

      // R8: colour code 11 has no legal entry
      op_wr(2'd0, 8'h06); set_ptr(0, 1'b1);
      op_rd(2'd3, d); op_rd(2'd0, t); op_idle();
      chk(d == 8'h00, "R8 colour 11 read", d, 0);
      chk(t == 8'h86, "R8 colour 11 error", t, 8'h86);

      // R7/R8: short coefficient range sweep
      op_wr(2'd0, 8'h01);
      op_rd(2'd0, t); op_idle();
      chk(t == 8'h01, "R9 error cleared by selector write", t, 1);
      set_ptr(0, 1'b1);
      for (int i = 0; i < 2730; i++) begin
         op_rd(2'd3, d);
         chk(d == cpat(i)[7:0], "R7 coef low byte", d, cpat(i)[7:0]);
         op_rd(2'd3, d);
         chk(d == cpat(i)[15:8], "R7 coef high byte", d, cpat(i)[15:8]);
      end
      op_rd(2'd3, d); op_rd(2'd0, t); op_idle();
      chk(d == 8'h00, "R8 short range end", d, 0);
      chk(t == 8'h81, "R8 short range error", t, 8'h81);

      // R8: long coefficient range
      op_wr(2'd0, 8'h09);
      set_ptr(2730, 1'b1);
      op_rd(2'd3, d); chk(d == cpat(2730)[7:0], "R8 long range 2730 lo", d, cpat(2730)[7:0]);
      op_rd(2'd3, d); chk(d == cpat(2730)[15:8], "R8 long range 2730 hi", d, cpat(2730)[15:8]);
      set_ptr(5459, 1'b1);
      op_rd(2'd3, d); chk(d == cpat(5459)[7:0], "R8 long range 5459 lo", d, cpat(5459)[7:0]);
      op_rd(2'd3, d); chk(d == cpat(5459)[15:8], "R8 long range 5459 hi", d, cpat(5459)[15:8]);
      op_rd(2'd0, t);
      chk(t == 8'h09, "R8 no error inside long range", t, 9);
      op_rd(2'd3, d); op_rd(2'd0, t); op_idle();
      chk(d == 8'h00, "R8 long range end", d, 0);
      chk(t == 8'h89, "R8 long range error", t, 8'h89);

      // R4: colour-table writes
      op_wr(2'd0, 8'h00); set_ptr(0, 1'b0);
      for (int i = 0; i < 16; i++) begin
         w0 = wcnt;
         op_wr(2'd3, 8'(i ^ 8'h5C)); op_idle();
         chk(wcnt == w0 + 1, "R4 write issued", wcnt, w0 + 1);
         chk(lw_addr == AW'(i) && lw_sel == 2'd0, "R4 write address", lw_addr, i);
         chk(lw_be == 2'b01 && lw_data[7:0] == 8'(i ^ 8'h5C), "R4 write lane", lw_data, i ^ 8'h5C);
      end
      chk_ptr("R4 pointer after 16 writes", 16, 1'b0);
      op_wr(2'd0, 8'h04); set_ptr(1023, 1'b0);
      w0 = wcnt;
      op_wr(2'd3, 8'hA5); op_idle();
      chk(wcnt == w0 + 1, "R4 write at 1023", wcnt, w0 + 1);
      chk(lw_sel == 2'd2 && lw_addr == AW'(1023), "R4 blue select and address", lw_addr, 1023);
      chk(lw_be == 2'b01 && lw_data[7:0] == 8'hA5, "R4 byte data", lw_data, 8'hA5);
      chk_ptr("R4 pointer advanced", 1024, 1'b0);
      op_wr(2'd3, 8'h5A); op_rd(2'd0, t); op_idle();
      chk(wcnt == w0 + 1, "R9 illegal write dropped", wcnt, w0 + 1);
      chk(t == 8'h84, "R9 error after illegal write", t, 8'h84);
      chk_ptr("R9 pointer unchanged", 1024, 1'b0);

      // R6: coefficient writes
      op_wr(2'd0, 8'h01); set_ptr(100, 1'b0);
      w0 = wcnt;
      op_wr(2'd3, 8'h11); op_idle();
      chk(wcnt == w0, "R6 first byte held", wcnt, w0);
      op_wr(2'd3, 8'h22); op_idle();
      chk(wcnt == w0 + 1, "R6 commit on second byte", wcnt, w0 + 1);
      chk(lw_sel == 2'd3 && lw_addr == AW'(100), "R6 coef address", lw_addr, 100);
      chk(lw_be == 2'b11 && lw_data == 16'h2211, "R6 coef data", lw_data, 16'h2211);
      chk_ptr("R6 pointer advanced", 101, 1'b0);

      // R10: pointer write mid-entry restarts at the first byte
      op_wr(2'd3, 8'h33);
      op_wr(2'd2, 8'd50);
      op_wr(2'd3, 8'h44);
      op_wr(2'd3, 8'h55); op_idle();
      chk(wcnt == w0 + 2, "R10 one commit after restart", wcnt, w0 + 2);
      chk(lw_addr == AW'(50) && lw_data == 16'h5544, "R10 restarted entry", lw_data, 16'h5544);
      set_ptr(7, 1'b1);
      op_rd(2'd3, d);
      op_wr(2'd2, 8'd7);
      op_rd(2'd3, t); op_idle();
      chk(t == cpat(7)[7:0], "R10 read phase restart", t, cpat(7)[7:0]);

      // R11: wrong-direction accesses
      op_wr(2'd2, 8'd7);
      w0 = wcnt;
      op_wr(2'd3, 8'h99); op_rd(2'd0, t); op_idle();
      chk(wcnt == w0, "R11 write in read dir dropped", wcnt, w0);
      chk(t[7] == 1'b0, "R11 no error for wrong direction", t, 1);
      chk_ptr("R11 pointer unchanged by write", 7, 1'b1);
      op_rd(2'd3, d); op_idle();
      chk(d == cpat(7)[7:0], "R11 phase unchanged", d, cpat(7)[7:0]);
      set_ptr(7, 1'b0);
      op_rd(2'd3, d); op_idle();
      chk(d == 8'h00, "R11 read in write dir", d, 0);
      chk_ptr("R11 pointer unchanged by read", 7, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule